// File: doc/BRIEF.md
# Sideband Message Bus Register Bridge

This block gives a host indirect access to a small register file inside a target unit that sits on an internal sideband message bus. The host sees two 32-bit registers at configuration offsets 0xD0 and 0xD4. The one at 0xD0 takes a command word. The one at 0xD4 carries data in both directions. Writing a command word starts one transaction. A read transaction copies a target register into the data register. A write transaction commits the value staged earlier in the data register.

The target unit is modelled inside the block. It is a file of six range registers that form three base/limit pairs. The host reaches them at offsets 0x10 to 0x15 on port 0x3. Bits [3:0] of every range register are its lock field, and address consumers mask them off. A register whose lock field is nonzero refuses every later write until reset. Each transaction holds a busy flag for a fixed number of cycles. Any rejected transaction sets a sticky error flag.

Top module: `sbmsg_bridge`

## Requirements
- R1: After reset, both host registers read 0, busy and err are low, and every range register reads 0.
- R2: A host read at 0xD0 returns the last accepted command word and a read at 0xD4 returns the data register; every other host address reads 0.
- R3: An accepted command word (host write at 0xD0 while not busy) holds busy high for exactly BUSY_CYCLES (default 4) consecutive cycles.
- R4: While busy is high, the data register keeps its previous value, and host writes to either register are ignored.
- R5: A command with opcode 0xD0 in bits [31:24], port 0x03 in [23:16], an offset from 0x10 to 0x15 in [15:8] and byte enables 0xF in [7:4] loads the full addressed range register, lock bits included, into the data register by the time busy falls.
- R6: A command with the same fields but opcode 0xE0 stores the staged data register into the addressed range register if that register is unlocked.
- R7: A command with any other opcode, any other port, an offset outside 0x10 to 0x15, or byte enables other than 0xF changes no register and sets err.
- R8: A write command to a range register whose bits [3:0] are nonzero leaves that register unchanged and sets err.
- R9: A stored value with a nonzero lock field locks the register. A stored value with lock field 0 leaves it writable.
- R10: Bits [3:0] of the command word have no effect on decoding.
- R11: err stays high once set, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 8 | Host configuration offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr (combinational) |
| busy | output | 1 | Transaction in progress |
| err | output | 1 | Sticky error flag |

## Verification
The hardest case to reach is a write refused by a lock. Only a range register that a previous command has already locked can refuse a write, and a lock survives everything except reset. Because err is sticky, every refused access before the lock test would hide the err that the lock produces. For that reason the bench first runs the unlocked round trips and the full illegal-field sweeps. It then resets the block, locks a register, and tries to overwrite it. It also writes to both host registers in the middle of a busy window to confirm those writes are dropped.

// File: rtl/sbmsg_bridge.sv
module sbmsg_bridge #(
  parameter int        NUM_REGS    = 6,
  parameter int        LOCK_W      = 4,
  parameter int        BUSY_CYCLES = 4,
  parameter logic [7:0] BASE_OFF   = 8'h10,
  parameter logic [7:0] TGT_PORT   = 8'h03,
  parameter logic [7:0] OP_RD      = 8'hD0,
  parameter logic [7:0] OP_WR      = 8'hE0,
  parameter logic [7:0] CTRL_ADDR  = 8'hD0,
  parameter logic [7:0] DATA_ADDR  = 8'hD4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic [7:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        busy,
  output logic        err
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  localparam int IW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [7:0] LAST_OFF = BASE_OFF + 8'(NUM_REGS - 1);

  logic [31:0]   ctrl_q, data_q;
  logic [31:0]   rng_q [NUM_REGS];
  logic [CW-1:0] cnt_q;

  wire [7:0] op   = ctrl_q[31:24];
  wire [7:0] port = ctrl_q[23:16];
  wire [7:0] off  = ctrl_q[15:8];
  wire [3:0] be   = ctrl_q[7:4];
  wire [7:0] rel  = off - BASE_OFF;
  wire [IW-1:0] idx = rel[IW-1:0];

  wire off_ok  = (off >= BASE_OFF) && (off <= LAST_OFF);
  wire legal   = (port == TGT_PORT) && (be == 4'hF) && off_ok &&
                 ((op == OP_RD) || (op == OP_WR));
  wire locked  = |rng_q[idx][LOCK_W-1:0];
  wire finish  = (cnt_q == CW'(1));

  assign busy = (cnt_q != '0);
  assign host_rdata = (host_addr == CTRL_ADDR) ? ctrl_q :
                      (host_addr == DATA_ADDR) ? data_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      data_q <= '0;
      cnt_q  <= '0;
      err    <= 1'b0;
      for (int i = 0; i < NUM_REGS; i++) rng_q[i] <= '0;
    end else begin
      if (host_we && !busy) begin
        if (host_addr == CTRL_ADDR) begin
          ctrl_q <= host_wdata;
          cnt_q  <= CW'(BUSY_CYCLES);
        end else if (host_addr == DATA_ADDR) begin
          data_q <= host_wdata;
        end
      end
      if (busy) cnt_q <= cnt_q - CW'(1);
      if (finish) begin
        if (!legal)            err <= 1'b1;
        else if (op == OP_RD)  data_q <= rng_q[idx];
        else if (locked)       err <= 1'b1;
        else                   rng_q[idx] <= data_q;
      end
    end
  end
endmodule

module sbmsg_bridge_chk #(
  parameter logic [7:0] CTRL_ADDR = 8'hD0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        host_we,
  input logic [7:0]  host_addr,
  input logic        busy,
  input logic        err,
  input logic [31:0] data_q
);
  assert_busy_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && !busy && host_addr == CTRL_ADDR) |=> busy);
  assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(data_q));
  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  assert_err_at_finish_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $fell(busy));
  assert_no_idle_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> (!$changed(data_q) || $past(host_we)));
endmodule

bind sbmsg_bridge sbmsg_bridge_chk #(.CTRL_ADDR(CTRL_ADDR)) chk_i (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
  .busy(busy), .err(err), .data_q(data_q));

// File: tb/sbmsg_bridge_tb.sv
module sbmsg_bridge_tb_top;
  localparam int CLK_P = 10;
  localparam int NB = 4;
  localparam logic [7:0] CA = 8'hD0, DA = 8'hD4;

  logic clk = 0, rst_n = 0, host_we = 0;
  logic [7:0] host_addr = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic busy, err;
  int runs = 0, fails = 0;
  logic [31:0] mdl [6];
  logic [31:0] exp_data;
  logic exp_err;

  always #(CLK_P/2) clk = ~clk;

  sbmsg_bridge dut_i (.clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy), .err(err));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 0;
  endtask

  task automatic host_rd(input logic [7:0] a, output logic [31:0] d);
    host_addr = a; #1; d = host_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 6; i++) mdl[i] = 0;
    exp_data = 0; exp_err = 0;
  endtask

  task automatic model(input logic [7:0] op, pt, of, input logic [3:0] be);
    int i;
    i = int'(of) - 16;
    if (pt != 8'h03 || be != 4'hF || of < 8'h10 || of > 8'h15 || (op != 8'hD0 && op != 8'hE0))
      exp_err = 1;
    else if (op == 8'hD0) exp_data = mdl[i];
    else if (mdl[i][3:0] != 0) exp_err = 1;
    else mdl[i] = exp_data;
  endtask

  task automatic cmd(input logic [7:0] op, pt, of, input logic [3:0] be, input logic [3:0] rsv);
    int n;
    host_wr(CA, {op, pt, of, be, rsv});
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check("R3 busy length", n, NB);
    model(op, pt, of, be);
  endtask

  task automatic stage(input logic [31:0] v);
    host_wr(DA, v); exp_data = v;
  endtask

  task automatic post(input string tag);
    logic [31:0] d;
    host_rd(DA, d);
    check(tag, d, exp_data);
    check({tag, " err"}, {31'b0, err}, {31'b0, exp_err});
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < 6; i++) begin
      cmd(8'hD0, 8'h03, 8'(16 + i), 4'hF, 4'h0);
      post(tag);
      check({tag, " value"}, exp_data, mdl[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    do_reset();
    host_rd(CA, d); check("R1 ctrl reset", d, 0);
    host_rd(DA, d); check("R1 data reset", d, 0);
    check("R1 busy reset", {31'b0, busy}, 0);
    check("R1 err reset", {31'b0, err}, 0);
    read_all("R1 range reset");

    stage(32'hA5A5_5A5A);
    host_rd(DA, d); check("R2 data readback", d, 32'hA5A5_5A5A);
    host_rd(8'hD8, d); check("R2 other addr", d, 0);
    host_rd(8'h00, d); check("R2 other addr", d, 0);

    for (int i = 0; i < 6; i++) begin
      stage(32'h1000_0000 * (i + 1) + 32'h0001_2340);
      cmd(8'hE0, 8'h03, 8'(16 + i), 4'hF, 4'(i));
      post("R6 write unlocked");
    end
    read_all("R5 read back");
    host_rd(CA, d); check("R2 ctrl readback", d, 32'hD003_15F0);
    for (int i = 0; i < 6; i++) begin
      stage(32'h0BAD_0000 + 32'(i) * 32'h110);
      cmd(8'hE0, 8'h03, 8'(16 + i), 4'hF, 4'hF);
      post("R9 rewrite lock-0");
    end
    read_all("R10 reserved bits ignored");

    host_wr(CA, 32'hD003_10F0);
    host_wr(DA, 32'hDEAD_BEEF);
    host_rd(DA, d); check("R4 data write in busy", d, exp_data);
    host_wr(CA, 32'hE003_11F0);
    host_rd(CA, d); check("R4 ctrl write in busy", d, 32'hD003_10F0);
    while (busy) @(negedge clk);
    model(8'hD0, 8'h03, 8'h10, 4'hF);
    post("R4 R5 after busy");

    cmd(8'hE1, 8'h03, 8'h10, 4'hF, 0);
    post("R7 first illegal");
    for (int op = 0; op < 256; op++)
      if (op != 'hD0 && op != 'hE0) begin cmd(8'(op), 8'h03, 8'h11, 4'hF, 0); post("R7 opcode sweep"); end
    for (int p = 0; p < 256; p += 5)
      if (p != 3) begin cmd(8'hD0, 8'(p), 8'h12, 4'hF, 0); post("R7 port sweep"); end
    for (int o = 0; o < 64; o++)
      if (o < 16 || o > 21) begin cmd(8'(o[0] ? 8'hE0 : 8'hD0), 8'h03, 8'(o), 4'hF, 0); post("R7 offset sweep"); end
    for (int b = 0; b < 15; b++) begin cmd(8'hE0, 8'h03, 8'h13, 4'(b), 0); post("R7 byte enable sweep"); end
    read_all("R7 R11 targets untouched");

    do_reset();
    post("R1 second reset");
    for (int i = 0; i < 6; i++) begin
      stage(32'h4000_0000 + 32'(i) * 32'h1000 + 32'(i + 1));
      cmd(8'hE0, 8'h03, 8'(16 + i), 4'hF, 0);
      post("R9 lock write accepted");
    end
    for (int i = 0; i < 6; i++) begin
      stage(32'h7777_7770);
      cmd(8'hE0, 8'h03, 8'(16 + i), 4'hF, 0);
      post("R8 locked write refused");
    end
    read_all("R8 R11 locked contents");
    check("R11 err held", {31'b0, err}, 1);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule